// File: doc/BRIEF.md
# Register Dump Frame Serializer

This block turns a request for a processor state dump into a fixed 13-byte frame and hands it, one byte at a time, to a byte-wide serial transmitter. It is triggered when the processor writes the dump address (0x7F10) in its I/O window. The address decode that produces the one-cycle start pulse sits outside this block.

On the start pulse the block copies the program counter, the A and B accumulators, the stack pointer, the instruction byte, the phase byte and the two condition flags into its own registers. The frame is therefore one consistent snapshot, even if the processor state moves on later.

Each byte is offered with a valid flag and is taken only in a cycle where the transmitter reports ready. The busy output stays high for the whole frame, and the processor uses it as a stall. The serial bit timing of the transmitter is not part of this block.

Top module: `regdump_serializer`

## Requirements
- R1: After reset `busy_o` and `tx_valid_o` are both 0.
- R2: A `start_i` pulse while idle raises `busy_o` and `tx_valid_o` at the next clock edge, with the frame's first byte, 0xD0, on `tx_data_o`.
- R3: Frame byte 1 is the constant 0x01.
- R4: Frame bytes 2 to 9 carry PC, A, B and SP in that order, each 16-bit value sent as its upper byte first and then its lower byte.
- R5: Frame byte 10 is the instruction byte and byte 11 is the phase byte. Byte 12 is the flags byte: bits 7 to 2 are zero, bit 1 is carry and bit 0 is zero.
- R6: Every frame byte comes from the values present at the start pulse. Input changes after that pulse never appear in the frame.
- R7: A byte is accepted only on a clock edge where `tx_valid_o` and `tx_ready_i` are both 1. While ready is low, `tx_data_o` holds its value and `tx_valid_o` stays high.
- R8: Exactly 13 bytes are accepted per frame. `busy_o` and `tx_valid_o` drop at the edge that accepts byte 12.
- R9: A `start_i` pulse while `busy_o` is 1 has no effect. This includes a pulse in the same cycle as the acceptance of the last byte: it neither restarts nor retakes the snapshot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-cycle dump request |
| pc_i | input | 16 | Program counter |
| a_i | input | 16 | Accumulator A |
| b_i | input | 16 | Accumulator B |
| sp_i | input | 16 | Stack pointer |
| ir_i | input | 8 | Instruction byte |
| phase_i | input | 8 | Execution phase byte |
| carry_i | input | 1 | Carry flag |
| zero_i | input | 1 | Zero flag |
| tx_ready_i | input | 1 | Transmitter can take a byte |
| tx_valid_o | output | 1 | A frame byte is offered |
| tx_data_o | output | 8 | Offered frame byte |
| busy_o | output | 1 | Dump in progress (processor stall) |

## Verification
The hardest case to reach from the ports is a new start request that arrives in the very cycle the transmitter takes the final byte. In that cycle the block is still busy, but it would be idle one edge later. The bench forces this case in dedicated runs: it raises ready and start together on byte 12, then checks that busy falls and stays low. Around it, random ready gaps, random start pulses during the frame, and input values that change every cycle after the snapshot test hold behaviour and snapshot isolation.

// File: rtl/regdump_pkg.sv
package regdump_pkg;

  localparam int BYTE_W     = 8;
  localparam int WORD_W     = 16;
  localparam int WORD_BYTES = WORD_W / BYTE_W;
  localparam int NUM_WORDS  = 4;
  localparam int HDR_LEN    = 2;
  localparam int TAIL_LEN   = 3;
  localparam int FRAME_LEN  = HDR_LEN + NUM_WORDS * WORD_BYTES + TAIL_LEN;
  localparam int IDX_W      = $clog2(FRAME_LEN);
  localparam int TAIL_BASE  = HDR_LEN + NUM_WORDS * WORD_BYTES;

  localparam logic [BYTE_W-1:0] HDR_SYNC = 8'hD0;
  localparam logic [BYTE_W-1:0] HDR_VER  = 8'h01;

  typedef struct packed {
    logic [WORD_W-1:0] pc;
    logic [WORD_W-1:0] a;
    logic [WORD_W-1:0] b;
    logic [WORD_W-1:0] sp;
    logic [BYTE_W-1:0] ir;
    logic [BYTE_W-1:0] phase;
    logic              carry;
    logic              zero;
  } snap_t;

  // Flags byte: zero padding above, carry in bit 1, zero in bit 0.
  function automatic logic [BYTE_W-1:0] pack_flags(input logic c, input logic z);
    return {{(BYTE_W-2){1'b0}}, c, z};
  endfunction

  // Byte k of a word, k = 0 being the most significant byte.
  function automatic logic [BYTE_W-1:0] word_byte(input logic [WORD_W-1:0] w,
                                                  input int unsigned k);
    return w[WORD_W-1-k*BYTE_W -: BYTE_W];
  endfunction

endpackage

// File: rtl/regdump_snapshot.sv
module regdump_snapshot
  import regdump_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  capture,
  input  snap_t live,
  output snap_t held
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held <= '0;
    end else if (capture) begin
      held <= live;
    end
  end
endmodule

// File: rtl/regdump_sequencer.sv
module regdump_sequencer
  import regdump_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             ready,
  output logic             busy,
  output logic [IDX_W-1:0] idx,
  output logic             capture,
  output logic             accept,
  output logic             last
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_LEN - 1);

  logic             busy_q;
  logic [IDX_W-1:0] idx_q;

  assign capture = start && !busy_q;
  assign accept  = busy_q && ready;
  assign last    = (idx_q == LAST_IDX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
    end else if (capture) begin
      busy_q <= 1'b1;
      idx_q  <= '0;
    end else if (accept) begin
      if (last) begin
        busy_q <= 1'b0;
        idx_q  <= '0;
      end else begin
        idx_q  <= idx_q + 1'b1;
      end
    end
  end

  assign busy = busy_q;
  assign idx  = idx_q;
endmodule

// File: rtl/regdump_byte_mux.sv
module regdump_byte_mux
  import regdump_pkg::*;
(
  input  snap_t             snap,
  input  logic [IDX_W-1:0]  idx,
  output logic [BYTE_W-1:0] data
);
  logic [BYTE_W-1:0] frame [FRAME_LEN];
  logic [WORD_W-1:0] words [NUM_WORDS];

  assign words[0] = snap.pc;
  assign words[1] = snap.a;
  assign words[2] = snap.b;
  assign words[3] = snap.sp;

  assign frame[0] = HDR_SYNC;
  assign frame[1] = HDR_VER;

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    for (genvar k = 0; k < WORD_BYTES; k++) begin : g_byte
      assign frame[HDR_LEN + w*WORD_BYTES + k] = word_byte(words[w], k);
    end
  end

  assign frame[TAIL_BASE]     = snap.ir;
  assign frame[TAIL_BASE + 1] = snap.phase;
  assign frame[TAIL_BASE + 2] = pack_flags(snap.carry, snap.zero);

  always_comb begin
    data = '0;
    for (int i = 0; i < FRAME_LEN; i++) begin
      if (idx == IDX_W'(i)) data = frame[i];
    end
  end
endmodule

// File: rtl/regdump_serializer.sv
module regdump_serializer
  import regdump_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic [15:0] pc_i,
  input  logic [15:0] a_i,
  input  logic [15:0] b_i,
  input  logic [15:0] sp_i,
  input  logic [7:0]  ir_i,
  input  logic [7:0]  phase_i,
  input  logic        carry_i,
  input  logic        zero_i,
  input  logic        tx_ready_i,
  output logic        tx_valid_o,
  output logic [7:0]  tx_data_o,
  output logic        busy_o
);
  snap_t            live_w;
  snap_t            snap_q;
  logic             capture_w;
  logic             accept_w;
  logic             last_w;
  logic             busy_w;
  logic [IDX_W-1:0] idx_w;

  assign live_w = '{pc: pc_i, a: a_i, b: b_i, sp: sp_i, ir: ir_i,
                    phase: phase_i, carry: carry_i, zero: zero_i};

  regdump_sequencer u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start_i),
    .ready   (tx_ready_i),
    .busy    (busy_w),
    .idx     (idx_w),
    .capture (capture_w),
    .accept  (accept_w),
    .last    (last_w)
  );

  regdump_snapshot u_snap (
    .clk     (clk),
    .rst_n   (rst_n),
    .capture (capture_w),
    .live    (live_w),
    .held    (snap_q)
  );

  regdump_byte_mux u_mux (
    .snap (snap_q),
    .idx  (idx_w),
    .data (tx_data_o)
  );

  assign tx_valid_o = busy_w;
  assign busy_o     = busy_w;
endmodule

// File: rtl/regdump_checker.sv
module regdump_checker
  import regdump_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic             tx_ready_i,
  input logic             tx_valid_o,
  input logic [7:0]       tx_data_o,
  input logic             busy_o,
  input logic [IDX_W-1:0] idx_w,
  input logic             accept_w,
  input logic             last_w,
  input snap_t            snap_q
);
  p_reset_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!busy_o && !tx_valid_o));

  p_start_header_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> (busy_o && tx_valid_o && tx_data_o == HDR_SYNC));

  p_second_header_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_w && idx_w == '0) |=> (tx_valid_o && tx_data_o == HDR_VER));

  p_pc_high_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid_o && idx_w == IDX_W'(HDR_LEN)) |-> (tx_data_o == snap_q.pc[15:8]));

  p_step_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_w && !last_w) |=> (idx_w == $past(idx_w) + 1'b1));

  p_flags_pad_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid_o && idx_w == IDX_W'(FRAME_LEN - 1)) |-> (tx_data_o[7:2] == '0));

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid_o && !tx_ready_i) |=> (tx_valid_o && $stable(tx_data_o)));

  p_frame_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_w && last_w) |=> (!busy_o && !tx_valid_o));

  p_busy_start_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |=> $stable(snap_q));
endmodule

bind regdump_serializer regdump_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start_i    (start_i),
  .tx_ready_i (tx_ready_i),
  .tx_valid_o (tx_valid_o),
  .tx_data_o  (tx_data_o),
  .busy_o     (busy_o),
  .idx_w      (idx_w),
  .accept_w   (accept_w),
  .last_w     (last_w),
  .snap_q     (snap_q)
);

// File: tb/test_regdump_serializer.sv
module test_regdump_serializer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [15:0] pc_i = '0, a_i = '0, b_i = '0, sp_i = '0;
  logic [7:0]  ir_i = '0, phase_i = '0;
  logic        carry_i = 1'b0, zero_i = 1'b0;
  logic        tx_ready_i = 1'b0;
  logic        tx_valid_o;
  logic [7:0]  tx_data_o;
  logic        busy_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  regdump_serializer i_regdump_serializer (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .pc_i(pc_i), .a_i(a_i), .b_i(b_i), .sp_i(sp_i),
    .ir_i(ir_i), .phase_i(phase_i), .carry_i(carry_i), .zero_i(zero_i),
    .tx_ready_i(tx_ready_i), .tx_valid_o(tx_valid_o),
    .tx_data_o(tx_data_o), .busy_o(busy_o)
  );

  // Expected frame as one 104-bit image, byte 0 in the top byte.
  function automatic logic [103:0] frame_image(logic [15:0] p, logic [15:0] a,
      logic [15:0] b, logic [15:0] s, logic [7:0] ir, logic [7:0] ph,
      logic c, logic z);
    return {8'hD0, 8'h01, p, a, b, s, ir, ph, 6'b000000, c, z};
  endfunction

  function automatic logic [7:0] image_byte(logic [103:0] img, int k);
    return img[103 - 8*k -: 8];
  endfunction

  function automatic string req_of(int k);
    if (k == 0) return "R2";
    if (k == 1) return "R3";
    if (k < 10) return "R4/R6";
    return "R5/R6";
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic scramble_inputs();
    pc_i = 16'($urandom); a_i = 16'($urandom); b_i = 16'($urandom);
    sp_i = 16'($urandom); ir_i = 8'($urandom); phase_i = 8'($urandom);
    carry_i = 1'($urandom); zero_i = 1'($urandom);
  endtask

  // One dump; ready_pct sets the ready density, end_poke raises start with the final acceptance.
  task automatic run_dump(int ready_pct, bit end_poke, bit mid_pokes);
    logic [103:0] img;
    int k;
    int cyc;
    @(negedge clk);
    scramble_inputs();
    img = frame_image(pc_i, a_i, b_i, sp_i, ir_i, phase_i, carry_i, zero_i);
    start_i = 1'b1;
    tx_ready_i = 1'b0;
    @(negedge clk);
    start_i = 1'b0;
    check(busy_o && tx_valid_o, "R2", {busy_o, tx_valid_o}, 3);
    k = 0;
    cyc = 0;
    while (k < 13 && cyc < 2000) begin
      scramble_inputs();  // R6: late input changes must not appear
      check(tx_valid_o && tx_data_o == image_byte(img, k), req_of(k),
            {tx_valid_o, tx_data_o}, {1'b1, image_byte(img, k)});  // also R7 hold
      start_i = mid_pokes && (k < 12) && ($urandom % 6 == 0);  // R9
      tx_ready_i = ($urandom % 100) < ready_pct;
      if (k == 12 && end_poke) begin
        tx_ready_i = 1'b1;
        start_i = 1'b1;
      end
      if (tx_ready_i) k++;
      @(negedge clk);
      cyc++;
    end
    start_i = 1'b0;
    tx_ready_i = 1'b0;
    check(cyc < 2000, "R7 watchdog", cyc, 0);
    check(!busy_o && !tx_valid_o, "R8", {busy_o, tx_valid_o}, 0);
    @(negedge clk);
    check(!busy_o && !tx_valid_o, "R9", {busy_o, tx_valid_o}, 0);
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    check(!busy_o && !tx_valid_o, "R1", {busy_o, tx_valid_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy_o && !tx_valid_o, "R1", {busy_o, tx_valid_o}, 0);
    // R7: ready held low for a long stretch, data must stay on byte 0
    @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (20) begin
      @(negedge clk);
      check(tx_valid_o && tx_data_o == 8'hD0, "R7", tx_data_o, 8'hD0);
    end
    repeat (13) begin
      tx_ready_i = 1'b1;
      @(negedge clk);
    end
    tx_ready_i = 1'b0;
    check(!busy_o, "R8", busy_o, 0);
    run_dump(100, 1'b0, 1'b0);  // back-to-back acceptance
    run_dump(100, 1'b1, 1'b0);  // start with final acceptance
    run_dump(10, 1'b0, 1'b1);   // sparse ready
    for (int n = 0; n < 40; n++) begin
      run_dump(20 + int'($urandom % 80), 1'($urandom), 1'b1);
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule